// File: doc/BRIEF.md
# Two-Port General-Purpose I/O Controller

This block is a memory-mapped GPIO peripheral that sits on an APB slave interface. It gives software control of sixteen pins, arranged as two independent 8-bit ports called A and B. Each port has a direction register and a data register. The direction register sets each pin to be an input or an output. The data register supplies the value that output pins drive. When read, the data register returns what each pin currently shows.

Each pad connects through three lines: a data-in line, a data-out line and an output-enable line. The two ports use opposite direction polarity. On port A a set direction bit turns the pin into an output. On port B a cleared direction bit turns the pin into an output. After reset both ports therefore come up as all inputs, with different register values.

Pad inputs pass through one register stage on the bus clock before software can read them. Register accesses complete with no wait states.

Top module: `gpio_pair`

## Requirements
- R1: While reset (active-low `presetn`) is asserted and right after it is released, every output enable is 0 and every data-out bit is 0. The port A direction register reads 0x00 and the port B direction register reads 0xFF.
- R2: A register changes only on a rising clock edge where `psel`, `penable` and `pwrite` are all high. A setup-phase cycle (`penable` low) or a read changes nothing.
- R3: Port A direction register at byte offset 0x04. Bit i = 1 makes pin i an output (`pa_oe[i]`=1). Bit i = 0 makes pin i an input.
- R4: Port B direction register at byte offset 0x0C. Bit i = 0 makes pin i an output (`pb_oe[i]`=1). Bit i = 1 makes pin i an input.
- R5: Writing the port A data register (offset 0x00) or the port B data register (offset 0x08) sets `pa_out` or `pb_out`, effective from the writing edge.
- R6: Reading a data register returns, bit by bit, the last written value for pins that are outputs and the sampled pad value for pins that are inputs.
- R7: Pad inputs are registered once on `pclk`. A read returns the pad value captured at the clock edge before the access phase, so a pad change during the access phase is not yet visible.
- R8: Each register occupies bits 7:0 of the 32-bit bus word. Bits 31:8 of `prdata` are always zero, and bits 31:8 of `pwdata` are ignored. Direction registers read back their stored value.
- R9: An offset other than 0x00, 0x04, 0x08 or 0x0C reads as zero, and a write to it changes no pin output or enable.
- R10: `prdata` is zero whenever the block is not addressed for a read (`psel` low or `pwrite` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (12) | Byte address within the block |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data |
| pa_in | input | PORT_W (8) | Port A pad data-in |
| pa_out | output | PORT_W (8) | Port A pad data-out |
| pa_oe | output | PORT_W (8) | Port A pad output enable |
| pb_in | input | PORT_W (8) | Port B pad data-in |
| pb_out | output | PORT_W (8) | Port B pad data-out |
| pb_oe | output | PORT_W (8) | Port B pad output enable |

## Verification
The bench builds the block with its default parameters: 8-bit ports, a 12-bit address and a 32-bit bus word. With these values the bench can place ones in `pwdata[31:8]` to show they are dropped. It can also reach offsets beyond 0x0C to show they decode as empty. The vector table mixes output and input pins within one port, so that a single data read shows both written bits and pad bits. Directed steps cover the setup-phase-only write, a pad change during the access phase, and a reset in the middle of a run.

// File: rtl/gpio_pair.sv
module gpio_pair #(
  parameter int PORT_W = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe
);

  localparam logic [ADDR_W-1:0] OFS_A_DAT = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_A_DIR = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_B_DAT = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFS_B_DIR = ADDR_W'('h0C);
  localparam int PAD_W = DATA_W - PORT_W;

  logic [PORT_W-1:0] dir_a, dir_b, dat_a, dat_b, smp_a, smp_b;
  logic [PORT_W-1:0] rd_a, rd_b, rd_sel;
  logic              wr_en, rd_en;
  logic              hit_a_dat, hit_a_dir, hit_b_dat, hit_b_dir;

  assign wr_en     = psel & penable & pwrite;
  assign rd_en     = psel & ~pwrite;
  assign hit_a_dat = (paddr == OFS_A_DAT);
  assign hit_a_dir = (paddr == OFS_A_DIR);
  assign hit_b_dat = (paddr == OFS_B_DAT);
  assign hit_b_dir = (paddr == OFS_B_DIR);

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      dir_a <= '0;
      dir_b <= '1;
      dat_a <= '0;
      dat_b <= '0;
    end else if (wr_en) begin
      if (hit_a_dat) dat_a <= pwdata[PORT_W-1:0];
      if (hit_a_dir) dir_a <= pwdata[PORT_W-1:0];
      if (hit_b_dat) dat_b <= pwdata[PORT_W-1:0];
      if (hit_b_dir) dir_b <= pwdata[PORT_W-1:0];
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      smp_a <= '0;
      smp_b <= '0;
    end else begin
      smp_a <= pa_in;
      smp_b <= pb_in;
    end
  end

  assign pa_oe  = dir_a;
  assign pb_oe  = ~dir_b;
  assign pa_out = dat_a;
  assign pb_out = dat_b;

  assign rd_a = (dat_a & pa_oe) | (smp_a & ~pa_oe);
  assign rd_b = (dat_b & pb_oe) | (smp_b & ~pb_oe);

  always_comb begin
    rd_sel = '0;
    if (hit_a_dat) rd_sel = rd_a;
    if (hit_a_dir) rd_sel = dir_a;
    if (hit_b_dat) rd_sel = rd_b;
    if (hit_b_dir) rd_sel = dir_b;
  end

  assign prdata = rd_en ? {{PAD_W{1'b0}}, rd_sel} : '0;

  p_reset_state_r1: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(presetn) |-> (pa_oe == '0 && pb_oe == '0 && pa_out == '0 && pb_out == '0));

  p_hold_no_access_r2: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable && pwrite) |=>
      ($stable(pa_oe) && $stable(pb_oe) && $stable(pa_out) && $stable(pb_out)));

  p_dir_a_polarity_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && paddr == OFS_A_DIR) |=> pa_oe == $past(pwdata[PORT_W-1:0]));

  p_dir_b_polarity_r4: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && paddr == OFS_B_DIR) |=> pb_oe == ~$past(pwdata[PORT_W-1:0]));

  p_pad_sampled_r7: assert property (@(posedge pclk) disable iff (!presetn)
    ($past(presetn) && psel && !pwrite && paddr == OFS_A_DAT) |->
      ((prdata[PORT_W-1:0] & ~pa_oe) == ($past(pa_in) & ~pa_oe)));

  p_upper_zero_r8: assert property (@(posedge pclk) disable iff (!presetn)
    prdata[DATA_W-1:PORT_W] == '0);

  p_unused_zero_r9: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && paddr != OFS_A_DAT && paddr != OFS_A_DIR &&
     paddr != OFS_B_DAT && paddr != OFS_B_DIR) |-> prdata == '0);

  p_idle_zero_r10: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && !pwrite) |-> prdata == '0);

endmodule

// File: tb/gpio_pair_bench.sv
module gpio_pair_bench;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [7:0]  pa_in = '0, pb_in = '0;
  logic [7:0]  pa_out, pa_oe, pb_out, pb_oe;

  int n_run = 0;
  int n_fail = 0;

  always #5 pclk = ~pclk;

  gpio_pair u_gpio_pair (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] ofs;
    logic [7:0] wd;
    logic [7:0] pa;
    logic [7:0] pb;
    logic [7:0] rd;
    logic [7:0] aoe;
    logic [7:0] boe;
    logic [7:0] aout;
    logic [7:0] bout;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 8'h00, 8'h5A, 8'h00, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h00, 4'd6},  // R6 all inputs
    '{1'b0, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 4'd1},  // R1 dir A
    '{1'b0, 8'h0C, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 4'd1},  // R1 dir B
    '{1'b1, 8'h04, 8'hF0, 8'h00, 8'h00, 8'h00, 8'hF0, 8'h00, 8'h00, 8'h00, 4'd3},  // R3
    '{1'b1, 8'h00, 8'hA5, 8'h00, 8'h00, 8'h00, 8'hF0, 8'h00, 8'hA5, 8'h00, 4'd5},  // R5
    '{1'b0, 8'h00, 8'h00, 8'h3C, 8'h00, 8'hAC, 8'hF0, 8'h00, 8'hA5, 8'h00, 4'd6},  // R6 mixed A
    '{1'b1, 8'h0C, 8'h0F, 8'h00, 8'h00, 8'h00, 8'hF0, 8'hF0, 8'hA5, 8'h00, 4'd4},  // R4
    '{1'b1, 8'h08, 8'h96, 8'h00, 8'h00, 8'h00, 8'hF0, 8'hF0, 8'hA5, 8'h96, 4'd5},  // R5
    '{1'b0, 8'h08, 8'h00, 8'h00, 8'hC3, 8'h93, 8'hF0, 8'hF0, 8'hA5, 8'h96, 4'd6},  // R6 mixed B
    '{1'b0, 8'h0C, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hF0, 8'hA5, 8'h96, 4'd8},  // R8 readback
    '{1'b1, 8'h10, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hF0, 8'hF0, 8'hA5, 8'h96, 4'd9},  // R9 write
    '{1'b0, 8'h10, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'hF0, 8'hF0, 8'hA5, 8'h96, 4'd9},  // R9 read
    '{1'b1, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF0, 8'hA5, 8'h96, 4'd3},  // R3
    '{1'b0, 8'h00, 8'h00, 8'h77, 8'h00, 8'h77, 8'h00, 8'hF0, 8'hA5, 8'h96, 4'd6},  // R6
    '{1'b1, 8'h0C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hA5, 8'h96, 4'd4},  // R4
    '{1'b0, 8'h08, 8'h00, 8'h00, 8'h11, 8'h96, 8'h00, 8'hFF, 8'hA5, 8'h96, 4'd6}   // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d,
                          input logic chg, input logic [7:0] new_pa);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    if (chg) pa_in = new_pa;
    #3;
    d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  logic [31:0] rv;

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #12;
    check("R1 oe in reset", {16'h0, pa_oe, pb_oe}, 32'h0);
    check("R1 out in reset", {16'h0, pa_out, pb_out}, 32'h0);
    @(negedge pclk); @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);
    check("R10 idle prdata", prdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge pclk);
      pa_in = VECS[i].pa; pb_in = VECS[i].pb;
      if (VECS[i].wr) begin
        bus_write({4'h0, VECS[i].ofs}, {24'h0, VECS[i].wd});
      end else begin
        bus_read({4'h0, VECS[i].ofs}, rv, 1'b0, 8'h00);
        n_run++;
        if (rv !== {24'h0, VECS[i].rd}) begin
          n_fail++;
          $display("FAIL R%0d row %0d prdata: actual %h expected %h",
                   VECS[i].req, i, rv, {24'h0, VECS[i].rd});
        end
      end
      n_run++;
      if ({pa_oe, pb_oe, pa_out, pb_out} !==
          {VECS[i].aoe, VECS[i].boe, VECS[i].aout, VECS[i].bout}) begin
        n_fail++;
        $display("FAIL R%0d row %0d pins: actual %h expected %h", VECS[i].req, i,
                 {pa_oe, pb_oe, pa_out, pb_out},
                 {VECS[i].aoe, VECS[i].boe, VECS[i].aout, VECS[i].bout});
      end
    end

    // R2: setup phase alone does not write
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h000; pwdata = 32'h0000_003C;
    @(negedge pclk);
    psel = 1'b0; pwrite = 1'b0;
    @(negedge pclk);
    check("R2 setup-only write", {24'h0, pa_out}, 32'h0000_00A5);

    // R8: upper write bits dropped, upper read bits zero
    bus_write(12'h004, 32'hFFFF_FF0F);
    check("R8 oe from low byte", {24'h0, pa_oe}, 32'h0000_000F);
    bus_read(12'h004, rv, 1'b0, 8'h00);
    check("R8 dir readback", rv, 32'h0000_000F);

    // R7: pad change during access phase not yet visible
    @(negedge pclk);
    pa_in = 8'h50;
    bus_read(12'h000, rv, 1'b1, 8'hA0);
    check("R7 sampled pad", rv, 32'h0000_0055);
    bus_read(12'h000, rv, 1'b0, 8'h00);
    check("R7 later pad", rv, 32'h0000_00A5);

    // R10: write cycle leaves prdata zero
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b1; paddr = 12'h00C; pwdata = 32'hFF;
    #1;
    check("R10 prdata on write", prdata, 32'h0);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;

    // R1: reset in mid-run
    @(negedge pclk);
    presetn = 1'b0;
    #2;
    check("R1 mid-run reset pins", {pa_oe, pb_oe, pa_out, pb_out}, 32'h0);
    @(negedge pclk);
    presetn = 1'b1;
    bus_read(12'h00C, rv, 1'b0, 8'h00);
    check("R1 dir B after reset", rv, 32'h0000_00FF);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule